// File: doc/BRIEF.md
# Hashed Page Table Walker

This engine resolves an address-translation miss by searching a hashed page table held in memory. A miss arrives as an effective address, a miss kind (instruction fetch, data load or data store) and a protection key bit. The engine also sees the sixteen segment registers and the table base/mask register. It picks the segment register named by the top nibble of the address, hashes the virtual segment identifier with the page index, and forms the address of a 64-byte group of eight 8-byte entries. Each entry has an upper word and a lower word. The engine then walks the group one word at a time over a single word-wide memory port.

When no upper word in the primary group matches, the engine inverts the hash, flags the compare word as secondary, and walks a second group. On a match it fetches the lower word and applies the referenced/changed and protection rules for the miss kind. It writes the lower word back only when it actually changed, then returns the entry. When neither group matches it reports a fault. Only one miss is in flight at a time. Requests and responses use valid/ready handshakes.

Memory port protocol: the engine raises `mem_req` with a stable address (plus `mem_we` and `mem_wdata` for a write) and holds it until `mem_ack`. The access completes in the cycle `mem_ack` is high, and read data is valid in that cycle.

Top module: `hpt_walker`

## Requirements
- R1: The segment word used is register number `req_ea[31:28]` of the sixteen packed in `seg_file` (register n in bits 32n+31..32n). Only its low 24 bits, the segment identifier, take part in the search.
- R2: The primary hash is `seg[18:0] ^ {3'b000, ea[27:12]}`. The group address is `{base[31:25], base[24:16] | (base[8:0] & hash[18:10]), hash[9:0], 6'b0}`. Entry n of a group sits at group + 8n (upper word) and group + 8n + 4 (lower word).
- R3: Entries 0 to 7 of a group are read in ascending order. The whole upper word must equal `{1'b1, seg[23:0], H, ea[27:22]}`, with H = 0 in the primary pass. An entry with bit 31 clear, or with any field different, does not match. The lower word is read only for the matching entry.
- R4: After all eight primary entries miss, the same scan runs on the group formed from the one's complement of the hash, with H = 1 in the compare word.
- R5: When both groups miss, the response carries `rsp_hit` = 0, `rsp_fault` = 1 (not found), both entry words 0, and no write is made.
- R6: On a match without a protection fault, the returned lower word always has the referenced bit (0x100) set, and `rsp_fault` = 0 with `rsp_hit` = 1.
- R7: For a data store (`req_kind` = 2) whose lower word has the changed bit (0x80) clear, the page-protection field (lower bits 1:0) decides the outcome. A value of 3 is a violation. A value of 0 or 1 with `req_key` = 1 is a violation. Otherwise the changed bit is set. When the changed bit is already set, no check is made.
- R8: For an instruction fetch (`req_kind` = 0), a set guarded bit (0x8) in the lower word is a violation. A data load (`req_kind` = 1) never faults on protection.
- R9: A violation returns `rsp_fault` = 2, `rsp_hit` = 0, the matched upper word and the unmodified lower word, with no write. On a hit the lower word is written to the entry's lower address exactly when its value changed.
- R10: `req_ready` is high only when no miss is in progress. `busy` is high from the accepting edge until the response handshake. A pending response holds all its fields stable until `rsp_ready`.
- R11: After reset, `req_ready` = 1 and `busy`, `mem_req` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Engine can accept a miss |
| req_ea | input | 32 | Missing effective address |
| req_kind | input | 2 | 0 instruction fetch, 1 data load, 2 data store |
| req_key | input | 1 | Protection key for the access |
| seg_file | input | 512 | Sixteen packed segment registers |
| tbl_base | input | 32 | Table origin (high half) and mask (low 9 bits) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_hit | output | 1 | Entry found without protection fault |
| rsp_fault | output | 2 | 0 none, 1 not found, 2 protection |
| rsp_hi | output | 32 | Upper word of the entry |
| rsp_lo | output | 32 | Lower word of the entry (as updated) |
| busy | output | 1 | Miss in progress |

## Verification
Two events can fall into one cycle. A finished response can be handed over while a new miss is already waiting, and the bench provokes this by holding `req_valid` high with a different address for the whole walk. It judges the case by requiring `req_ready` low until the handshake edge and seeing no extra memory traffic afterwards. The other coincidence is the mismatch of the eighth primary entry together with the switch to the secondary group. A behavioural model predicts the exact next read address, so the first secondary read is compared against the complemented-hash group, entry 0. Response back-pressure is added on one miss so that stability of the held response is checked every stalled cycle.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  localparam int WORD_W  = 32;
  localparam int HASH_W  = 19;
  localparam int VSID_W  = 24;
  localparam int API_W   = 6;
  localparam int PIDX_W  = 16;
  localparam int MASK_W  = 9;

  localparam logic [WORD_W-1:0] LO_REF = 32'h0000_0100;
  localparam logic [WORD_W-1:0] LO_CHG = 32'h0000_0080;
  localparam logic [WORD_W-1:0] LO_GRD = 32'h0000_0008;

  typedef enum logic [1:0] {
    MISS_IFETCH = 2'd0,
    MISS_LOAD   = 2'd1,
    MISS_STORE  = 2'd2
  } miss_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_NOTFOUND = 2'd1,
    FLT_PROT     = 2'd2
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HI,
    ST_RD_LO,
    ST_WR_LO,
    ST_RESP
  } walk_state_e;

  // hash of segment identifier low bits and page index
  function automatic logic [HASH_W-1:0] pri_hash(
    input logic [HASH_W-1:0] vsid_lo,
    input logic [PIDX_W-1:0] page_idx
  );
    return vsid_lo ^ {{(HASH_W-PIDX_W){1'b0}}, page_idx};
  endfunction

  // group address from origin field, mask field and hash
  function automatic logic [WORD_W-1:0] grp_addr(
    input logic [15:0]        org,
    input logic [MASK_W-1:0]  msk,
    input logic [HASH_W-1:0]  h
  );
    return {org[15:9], org[8:0] | (msk & h[HASH_W-1:10]), h[9:0], 6'b00_0000};
  endfunction

  // expected upper word of a matching entry
  function automatic logic [WORD_W-1:0] cmp_word(
    input logic [VSID_W-1:0] vsid,
    input logic              sec,
    input logic [API_W-1:0]  api
  );
    return {1'b1, vsid, sec, api};
  endfunction

endpackage

// File: rtl/hpt_seg_select.sv
module hpt_seg_select #(
  parameter int SEG_COUNT = 16,
  parameter int SEL_W     = $clog2(SEG_COUNT)
) (
  input  logic [SEG_COUNT*hpt_pkg::WORD_W-1:0] seg_file,
  input  logic [SEL_W-1:0]                     sel,
  output logic [hpt_pkg::WORD_W-1:0]           seg_word
);
  logic [hpt_pkg::WORD_W-1:0] segs [SEG_COUNT];

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_unpack
    assign segs[g] = seg_file[g*hpt_pkg::WORD_W +: hpt_pkg::WORD_W];
  end

  assign seg_word = segs[sel];
endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
  parameter int IDX_W = 3
) (
  input  logic [31:0]      seg,
  input  logic [31:0]      ea,
  input  logic [31:0]      base,
  input  logic             sec,
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      grp,
  output logic [31:0]      ent_hi_addr,
  output logic [31:0]      ent_lo_addr,
  output logic [31:0]      cmp
);
  import hpt_pkg::*;

  logic [HASH_W-1:0] h_pri;
  logic [HASH_W-1:0] h_sel;
  logic              unused_bits;

  assign h_pri = pri_hash(seg[HASH_W-1:0], ea[27:12]);
  assign h_sel = sec ? ~h_pri : h_pri;
  assign grp   = grp_addr(base[31:16], base[MASK_W-1:0], h_sel);
  assign cmp   = cmp_word(seg[VSID_W-1:0], sec, ea[27:22]);

  assign ent_hi_addr = grp | (32'(idx) << 3);
  assign ent_lo_addr = ent_hi_addr | 32'h4;

  assign unused_bits = ^{seg[31:VSID_W], ea[31:28], ea[11:0], base[15:MASK_W]};
endmodule

// File: rtl/hpt_lo_update.sv
module hpt_lo_update (
  input  hpt_pkg::miss_kind_e kind,
  input  logic                key,
  input  logic [31:0]         lo_in,
  output logic [31:0]         lo_out,
  output logic                viol,
  output logic                changed
);
  import hpt_pkg::*;

  always_comb begin
    lo_out = lo_in | LO_REF;
    viol   = 1'b0;
    case (kind)
      MISS_IFETCH: viol = (lo_in & LO_GRD) != '0;
      MISS_STORE: begin
        if ((lo_in & LO_CHG) == '0) begin
          if (lo_in[1:0] == 2'b11)      viol = 1'b1;
          else if (!lo_in[1] && key)    viol = 1'b1;
          else                          lo_out = lo_out | LO_CHG;
        end
      end
      default: ;
    endcase
  end

  assign changed = (lo_out != lo_in);
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int GROUP_ENTRIES = 8,
  parameter int SEG_COUNT     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [31:0]            req_ea,
  input  logic [1:0]             req_kind,
  input  logic                   req_key,
  input  logic [SEG_COUNT*32-1:0] seg_file,
  input  logic [31:0]            tbl_base,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [31:0]            mem_addr,
  output logic [31:0]            mem_wdata,
  input  logic                   mem_ack,
  input  logic [31:0]            mem_rdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic                   rsp_hit,
  output logic [1:0]             rsp_fault,
  output logic [31:0]            rsp_hi,
  output logic [31:0]            rsp_lo,
  output logic                   busy
);
  import hpt_pkg::*;

  localparam int IDX_W = $clog2(GROUP_ENTRIES);
  localparam int SEL_W = $clog2(SEG_COUNT);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GROUP_ENTRIES - 1);

  walk_state_e      st_q;
  logic [31:0]      ea_q, seg_q, base_q, hi_q, lo_q;
  miss_kind_e       kind_q;
  logic             key_q, sec_q, hit_q;
  logic [IDX_W-1:0] idx_q;
  fault_e           fault_q;

  logic [31:0] seg_word, grp, ent_hi_addr, ent_lo_addr, cmp;
  logic [31:0] upd_lo;
  logic        upd_viol, upd_changed;

  // named events for the checker
  logic ev_accept, ev_match, ev_group_done, ev_rsp_done;

  hpt_seg_select #(.SEG_COUNT(SEG_COUNT)) u_seg (
    .seg_file (seg_file),
    .sel      (req_ea[31 -: SEL_W]),
    .seg_word (seg_word)
  );

  hpt_addr_gen #(.IDX_W(IDX_W)) u_addr (
    .seg         (seg_q),
    .ea          (ea_q),
    .base        (base_q),
    .sec         (sec_q),
    .idx         (idx_q),
    .grp         (grp),
    .ent_hi_addr (ent_hi_addr),
    .ent_lo_addr (ent_lo_addr),
    .cmp         (cmp)
  );

  hpt_lo_update u_upd (
    .kind    (kind_q),
    .key     (key_q),
    .lo_in   (mem_rdata),
    .lo_out  (upd_lo),
    .viol    (upd_viol),
    .changed (upd_changed)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);

  assign ev_accept     = req_valid && req_ready;
  assign ev_match      = (st_q == ST_RD_HI) && mem_ack && (mem_rdata == cmp);
  assign ev_group_done = (st_q == ST_RD_HI) && mem_ack && !ev_match && (idx_q == IDX_LAST);
  assign ev_rsp_done   = (st_q == ST_RESP) && rsp_ready;

  assign mem_req   = (st_q == ST_RD_HI) || (st_q == ST_RD_LO) || (st_q == ST_WR_LO);
  assign mem_we    = (st_q == ST_WR_LO);
  assign mem_addr  = (st_q == ST_RD_HI) ? ent_hi_addr : ent_lo_addr;
  assign mem_wdata = lo_q;

  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_hit   = hit_q;
  assign rsp_fault = fault_q;
  assign rsp_hi    = hi_q;
  assign rsp_lo    = lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ea_q    <= '0;
      seg_q   <= '0;
      base_q  <= '0;
      kind_q  <= MISS_LOAD;
      key_q   <= 1'b0;
      sec_q   <= 1'b0;
      idx_q   <= '0;
      hit_q   <= 1'b0;
      fault_q <= FLT_NONE;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (ev_accept) begin
            ea_q    <= req_ea;
            seg_q   <= seg_word;
            base_q  <= tbl_base;
            kind_q  <= miss_kind_e'(req_kind);
            key_q   <= req_key;
            sec_q   <= 1'b0;
            idx_q   <= '0;
            hit_q   <= 1'b0;
            fault_q <= FLT_NONE;
            hi_q    <= '0;
            lo_q    <= '0;
            st_q    <= ST_RD_HI;
          end
        end
        ST_RD_HI: begin
          if (mem_ack) begin
            if (ev_match) begin
              hi_q <= mem_rdata;
              st_q <= ST_RD_LO;
            end else if (ev_group_done) begin
              if (sec_q) begin
                fault_q <= FLT_NOTFOUND;
                st_q    <= ST_RESP;
              end else begin
                sec_q <= 1'b1;
                idx_q <= '0;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_RD_LO: begin
          if (mem_ack) begin
            if (upd_viol) begin
              lo_q    <= mem_rdata;
              fault_q <= FLT_PROT;
              st_q    <= ST_RESP;
            end else begin
              lo_q  <= upd_lo;
              hit_q <= 1'b1;
              st_q  <= upd_changed ? ST_WR_LO : ST_RESP;
            end
          end
        end
        ST_WR_LO: begin
          if (mem_ack) st_q <= ST_RESP;
        end
        ST_RESP: begin
          if (ev_rsp_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             busy,
  input logic             mem_req,
  input logic             mem_we,
  input logic [31:0]      mem_addr,
  input logic             mem_ack,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [1:0]       rsp_fault,
  input logic [31:0]      rsp_hi,
  input logic [31:0]      rsp_lo,
  input logic             ev_group_done,
  input logic             pass_secondary,
  input logic [IDX_W-1:0] ent_idx
);
  // R10
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy);

  // R10
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> !busy && !rsp_valid);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hi) && $stable(rsp_lo)
                                && $stable(rsp_fault) && $stable(rsp_hit));

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R9
  wb_lower_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[2:0] == 3'd4);

  // R4
  secondary_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_group_done && !pass_secondary |=> pass_secondary && ent_idx == '0);

  // R5
  notfound_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault == 2'd1 |-> !rsp_hit && rsp_lo == '0 && rsp_hi == '0);

  // R6
  hit_ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_hit |-> rsp_lo[8] && rsp_fault == 2'd0);
endmodule

bind hpt_walker hpt_walker_chk #(.IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .busy           (busy),
  .mem_req        (mem_req),
  .mem_we         (mem_we),
  .mem_addr       (mem_addr),
  .mem_ack        (mem_ack),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_hit        (rsp_hit),
  .rsp_fault      (rsp_fault),
  .rsp_hi         (rsp_hi),
  .rsp_lo         (rsp_lo),
  .ev_group_done  (ev_group_done),
  .pass_secondary (sec_q),
  .ent_idx        (idx_q)
);

// File: tb/tb_hpt_walker.sv
module tb_hpt_walker;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_ea = '0;
  logic [1:0]   req_kind = '0;
  logic         req_key = 1'b0;
  logic [511:0] seg_file = '0;
  logic [31:0]  tbl_base = '0;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr, mem_wdata;
  logic         mem_ack;
  logic [31:0]  mem_rdata;
  logic         rsp_valid;
  logic         rsp_ready = 1'b0;
  logic         rsp_hit;
  logic [1:0]   rsp_fault;
  logic [31:0]  rsp_hi, rsp_lo;
  logic         busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] segs [16];
  logic [31:0] mem [bit [31:0]];
  logic        ack_r = 1'b0;
  logic [31:0] rdata_r = '0;

  logic [31:0] q_addr [$];
  bit          q_we   [$];
  logic [31:0] q_wd   [$];
  bit          e_hit;
  logic [1:0]  e_fault;
  logic [31:0] e_hi, e_lo;

  hpt_walker dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_kind(req_kind), .req_key(req_key),
    .seg_file(seg_file), .tbl_base(tbl_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_hi(rsp_hi), .rsp_lo(rsp_lo), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] memrd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  // memory model: acknowledges each access one cycle after it is raised
  always @(posedge clk) begin
    if (!rst_n) begin
      ack_r <= 1'b0;
    end else begin
      if (mem_req && !ack_r) rdata_r <= memrd(mem_addr);
      if (mem_req && mem_we && ack_r) mem[mem_addr] = mem_wdata;
      ack_r <= mem_req && !ack_r;
    end
  end
  assign mem_ack   = ack_r;
  assign mem_rdata = rdata_r;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [31:0] m_vsid(input logic [31:0] ea);
    return segs[ea / 32'h1000_0000] % 32'h0100_0000;
  endfunction

  function automatic logic [18:0] m_hash(input logic [31:0] ea, input bit pass);
    logic [31:0] h;
    h = (m_vsid(ea) % 32'h8_0000) ^ ((ea / 32'h1000) % 32'h1_0000);
    if (pass) h = 32'h7_FFFF - h;
    return h[18:0];
  endfunction

  function automatic logic [31:0] m_group(input logic [18:0] h);
    logic [31:0] hv, top, mid;
    hv  = {13'b0, h};
    top = tbl_base & 32'hFE00_0000;
    mid = ((tbl_base / 32'h1_0000) % 32'h200) | ((tbl_base % 32'h200) & (hv / 32'h400));
    return top + mid * 32'h1_0000 + (hv % 32'h400) * 32'h40;
  endfunction

  function automatic logic [31:0] m_cmp(input logic [31:0] ea, input bit pass);
    return 32'h8000_0000 + m_vsid(ea) * 32'h80 + (pass ? 32'h40 : 32'h0)
           + (ea / 32'h40_0000) % 32'h40;
  endfunction

  function automatic logic [31:0] m_slot(input logic [31:0] ea, input bit pass, input int slot);
    return m_group(m_hash(ea, pass)) + 32'(slot) * 8;
  endfunction

  task automatic place(input logic [31:0] ea, input bit pass, input int slot, input logic [31:0] lo);
    mem[m_slot(ea, pass, slot)]     = m_cmp(ea, pass);
    mem[m_slot(ea, pass, slot) + 4] = lo;
  endtask

  task automatic decoy(input logic [31:0] ea, input bit pass, input int slot, input logic [31:0] w);
    mem[m_slot(ea, pass, slot)]     = w;
    mem[m_slot(ea, pass, slot) + 4] = 32'hDEAD_0000;
  endtask

  task automatic build_expect(input logic [31:0] ea, input logic [1:0] kind, input bit key);
    q_addr.delete(); q_we.delete(); q_wd.delete();
    e_hit = 0; e_fault = 2'd1; e_hi = 0; e_lo = 0;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 8; i++) begin
        logic [31:0] a, lo, nlo;
        bit bad;
        a = m_slot(ea, pass[0], i);
        q_addr.push_back(a); q_we.push_back(0); q_wd.push_back(0);
        if (memrd(a) == m_cmp(ea, pass[0])) begin
          q_addr.push_back(a + 4); q_we.push_back(0); q_wd.push_back(0);
          lo = memrd(a + 4);
          nlo = lo | 32'h100;
          bad = 0;
          if (kind == 2'd0 && (lo & 32'h8) != 0) bad = 1;
          if (kind == 2'd2 && (lo & 32'h80) == 0) begin
            if ((lo % 4) == 3) bad = 1;
            else if ((lo % 4) < 2 && key) bad = 1;
            else nlo = nlo | 32'h80;
          end
          e_hi = m_cmp(ea, pass[0]);
          if (bad) begin
            e_fault = 2'd2; e_lo = lo;
          end else begin
            e_hit = 1; e_fault = 2'd0; e_lo = nlo;
            if (nlo != lo) begin
              q_addr.push_back(a + 4); q_we.push_back(1); q_wd.push_back(nlo);
            end
          end
          return;
        end
      end
    end
  endtask

  // one miss; starts and ends just after a falling edge
  task automatic run_miss(input logic [31:0] ea, input logic [1:0] kind, input bit key,
                          input int stall, input string tag);
    int cyc = 0;
    bit fin = 0;
    int st = stall;
    build_expect(ea, kind, key);
    req_ea = ea; req_kind = kind; req_key = key; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R10", "ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_ea = ea ^ 32'h5000_0000;  // competing request held while busy
    while (!fin) begin
      chk(busy == 1'b1 && req_ready == 1'b0, "R10", "busy during walk",
          {busy, req_ready}, 32'h2);
      if (mem_req && mem_ack) begin
        if (q_addr.size() == 0) begin
          chk(0, tag, "unexpected access", mem_addr, 32'h0);
        end else begin
          logic [31:0] ea_x, wd_x;
          bit we_x;
          ea_x = q_addr.pop_front(); we_x = q_we.pop_front(); wd_x = q_wd.pop_front();
          chk(mem_addr == ea_x, tag, "access address", mem_addr, ea_x);
          chk(mem_we == we_x, tag, "access kind", 32'(mem_we), 32'(we_x));
          if (we_x) chk(mem_wdata == wd_x, "R9", "write data", mem_wdata, wd_x);
        end
      end
      if (rsp_valid) begin
        chk(rsp_hit == e_hit, tag, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
        chk(rsp_fault == e_fault, tag, "rsp_fault", 32'(rsp_fault), 32'(e_fault));
        chk(rsp_hi == e_hi, tag, "rsp_hi", rsp_hi, e_hi);
        chk(rsp_lo == e_lo, tag, "rsp_lo", rsp_lo, e_lo);
        if (st > 0) begin
          st--; rsp_ready = 1'b0;
        end else begin
          rsp_ready = 1'b1; fin = 1;
        end
      end
      cyc++;
      if (cyc > 400) begin
        chk(0, tag, "walk watchdog", 32'(cyc), 32'd400);
        fin = 1;
      end
      @(negedge clk);
    end
    rsp_ready = 1'b0; req_valid = 1'b0;
    chk(busy == 1'b0 && rsp_valid == 1'b0, "R10", "idle after handshake",
        {busy, rsp_valid}, 32'h0);
    chk(req_ready == 1'b1, "R10", "ready after handshake", 32'(req_ready), 32'd1);
    chk(q_addr.size() == 0, tag, "missing accesses", 32'(q_addr.size()), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a_ea, b_ea, c_ea, d_ea, e_ea, f_ea, g_ea, h_ea, i_ea, j_ea, k_ea;
    for (int i = 0; i < 16; i++) begin
      segs[i] = 32'h6C00_0000 | ((32'(i) * 32'h0004_1A37 + 32'h0000_0B15) & 32'h00FF_FFFF);
      seg_file[i*32 +: 32] = segs[i];
    end
    tbl_base = 32'h03F8_0007;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "req_ready", 32'(req_ready), 32'd1);
    chk(busy == 1'b0, "R11", "busy", 32'(busy), 32'd0);
    chk(mem_req == 1'b0, "R11", "mem_req", 32'(mem_req), 32'd0);
    chk(rsp_valid == 1'b0, "R11", "rsp_valid", 32'(rsp_valid), 32'd0);

    // R2 R6: primary hit in slot 0, referenced bit added and written
    a_ea = 32'h1234_5678;
    place(a_ea, 0, 0, 32'h0004_5002);
    run_miss(a_ea, 2'd1, 0, 0, "R2");
    chk(memrd(m_slot(a_ea, 0, 0) + 4) == 32'h0004_5102, "R6", "stored lower",
        memrd(m_slot(a_ea, 0, 0) + 4), 32'h0004_5102);

    // R3: decoys ahead of the match, stalled response, no write (R already set)
    b_ea = 32'h2ABC_D000;
    decoy(b_ea, 0, 0, m_cmp(b_ea, 0) & 32'h7FFF_FFFF);
    decoy(b_ea, 0, 1, m_cmp(b_ea, 1));
    decoy(b_ea, 0, 2, m_cmp(b_ea, 0) ^ 32'h1);
    decoy(b_ea, 0, 3, m_cmp(b_ea, 0) ^ 32'h80);
    decoy(b_ea, 0, 4, 32'h0);
    place(b_ea, 0, 5, 32'h0007_7102);
    run_miss(b_ea, 2'd1, 0, 3, "R3");

    // R4: primary full of near misses, match in secondary slot 7
    c_ea = 32'h3000_4000;
    for (int s = 0; s < 8; s++) decoy(c_ea, 0, s, m_cmp(c_ea, 0) ^ 32'h2);
    place(c_ea, 1, 7, 32'h0009_9000);
    run_miss(c_ea, 2'd1, 0, 0, "R4");

    // R5: nothing matches in either group
    d_ea = 32'h4777_7000;
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 8; s++) decoy(d_ea, p[0], s, m_cmp(d_ea, p[0]) ^ 32'h100);
    run_miss(d_ea, 2'd1, 0, 0, "R5");

    // R7: store, protection 3 -> violation, lower untouched (R9)
    e_ea = 32'h5111_1000;
    place(e_ea, 0, 2, 32'h000A_A003);
    run_miss(e_ea, 2'd2, 0, 0, "R7");
    chk(memrd(m_slot(e_ea, 0, 2) + 4) == 32'h000A_A003, "R9", "no write on violation",
        memrd(m_slot(e_ea, 0, 2) + 4), 32'h000A_A003);

    // R7: protection 1 with key set -> violation; key clear -> changed bit set
    f_ea = 32'h6222_2000;
    place(f_ea, 0, 1, 32'h000B_B001);
    run_miss(f_ea, 2'd2, 1, 0, "R7");
    run_miss(f_ea, 2'd2, 0, 0, "R7");
    chk(memrd(m_slot(f_ea, 0, 1) + 4) == 32'h000B_B181, "R7", "stored changed+ref",
        memrd(m_slot(f_ea, 0, 1) + 4), 32'h000B_B181);
    // R9: second store finds both bits set -> no write
    run_miss(f_ea, 2'd2, 1, 0, "R9");

    // R7: changed already set, protection 3 is not checked
    k_ea = 32'h9666_6000;
    place(k_ea, 0, 3, 32'h000E_E183);
    run_miss(k_ea, 2'd2, 1, 0, "R7");

    // R8: instruction fetch on a guarded page, then an unguarded one
    g_ea = 32'h7333_3000;
    place(g_ea, 0, 0, 32'h000C_C00A);
    run_miss(g_ea, 2'd0, 0, 0, "R8");
    h_ea = 32'h8444_4000;
    place(h_ea, 0, 4, 32'h000D_D003);
    run_miss(h_ea, 2'd0, 1, 0, "R8");
    // R8: a load on the guarded page does not fault
    run_miss(g_ea, 2'd1, 0, 0, "R8");

    // R1: segment 15 entry; same low address bits via segment 0 must not find it
    i_ea = 32'hF555_5000;
    j_ea = 32'h0555_5000;
    place(i_ea, 0, 6, 32'h000F_F002);
    run_miss(i_ea, 2'd2, 1, 0, "R1");
    run_miss(j_ea, 2'd1, 0, 0, "R1");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule